// File: doc/BRIEF.md
# Rounding Saturating Fixed-Point Multiplier

This block multiplies two 16-bit signed two's-complement fixed-point numbers that carry the same number of fraction bits, `FRAC_BITS`, and returns a product in that same format. The full 32-bit product is kept, a rounding constant of half a result LSB is added, and the sum is shifted right arithmetically by `FRAC_BITS`. If the rescaled value does not fit in 16 signed bits, it is clamped to the nearest limit and an overflow flag is raised with that result.

Operands enter through a valid/ready handshake. By default the result leaves through one output register that stalls correctly under back-pressure. Setting `OUT_REG` to 0 removes that register and makes the block a purely combinational path that passes the handshake straight through.

Top module: `fxm_mul_round_sat`

## Requirements
- R1: With `FRAC_BITS` = N (1 to 15), `res_o` equals the 32-bit product `op_a*op_b`, plus 2^(N-1), arithmetically shifted right by N, whenever that value lies in [-32768, 32767].
- R2: A product that lies exactly halfway between two result codes rounds toward plus infinity. With N=8: 1×128 gives 1, -1×128 gives 0, and -3×128 gives -1.
- R3: A rescaled value above 32767 produces `res_o` = 0x7FFF with `ovf_o` = 1.
- R4: A rescaled value below -32768 produces `res_o` = 0x8000 with `ovf_o` = 1.
- R5: `ovf_o` is 0 whenever the result was not clamped, and `ovf_o` is never 1 while `out_valid` is 0.
- R6: With `OUT_REG`=1, an operand pair accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `res_o`/`ovf_o` with `out_valid` high from that edge onward.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `res_o` and `ovf_o` keep their values.
- R8: `in_ready` is 1 exactly when the output register is empty or `out_ready` is 1.
- R9: After a synchronous active-low reset, `out_valid` and `ovf_o` are 0.
- R10: The product is formed at full double width, so the extremes -32768×-32768 and 32767×32767 saturate to 0x7FFF rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair |
| op_a | input | 16 | Multiplicand, signed, FRAC_BITS fraction bits |
| op_b | input | 16 | Multiplier, signed, FRAC_BITS fraction bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res_o | output | 16 | Rounded, saturated product |
| ovf_o | output | 1 | Result was clamped |

## Verification
Exact halfway products of both signs separate round-half-up from truncation and from rounding away from zero. Products of the extreme codes, and large random operands, reach both clamp limits and show whether the product was computed at full width or wrapped. Small random operands stay in range and check the shift amount and the overflow flag. Throughout, a random `out_ready` pattern stalls the output register at random cycles, which exercises the hold, drain and acceptance timing against a behavioural model.

// File: rtl/fxm_pkg.sv
// Package: shared widths and types for the fixed-point multiplier.
// Assumes both operands and the result use one 16-bit signed format.
package fxm_pkg;
    localparam int DATA_W = 16;
    localparam int PROD_W = 2 * DATA_W;

    typedef logic signed [DATA_W-1:0] fx_t;
    typedef logic signed [PROD_W-1:0] fx_wide_t;

    typedef struct packed {
        fx_t  value;
        logic clamped;
    } fx_res_t;
endpackage

// File: rtl/fxm_product.sv
// fxm_product: full-width signed product of two operands.
// Assumes two's-complement inputs; the output never overflows.
module fxm_product
    import fxm_pkg::*;
(
    input  fx_t      a_i,
    input  fx_t      b_i,
    output fx_wide_t prod_o
);
    // Sign-extend both operands to the product width, then multiply.
    always_comb begin
        prod_o = fx_wide_t'(a_i) * fx_wide_t'(b_i);
    end
endmodule

// File: rtl/fxm_rescale.sv
// fxm_rescale: adds half an output LSB, then shifts arithmetically right.
// Assumes 1 <= FRAC_BITS <= 15. The sum cannot overflow, because the
// largest product magnitude is 2^30.
module fxm_rescale
    import fxm_pkg::*;
#(
    parameter int FRAC_BITS = 8
) (
    input  fx_wide_t prod_i,
    output fx_wide_t scaled_o
);
    localparam fx_wide_t HALF_LSB = fx_wide_t'(1) <<< (FRAC_BITS - 1);

    fx_wide_t rounded;

    // Round half up, then drop the extra fraction bits.
    always_comb begin
        rounded  = prod_i + HALF_LSB;
        scaled_o = rounded >>> FRAC_BITS;
    end
endmodule

// File: rtl/fxm_saturate.sv
// fxm_saturate: clamps a wide signed value to the 16-bit signed range.
// Assumes a signed input. clamped is set only when the value is limited.
module fxm_saturate
    import fxm_pkg::*;
(
    input  fx_wide_t wide_i,
    output fx_res_t  res_o
);
    localparam fx_wide_t POS_LIM = fx_wide_t'(2 ** (DATA_W - 1) - 1);
    localparam fx_wide_t NEG_LIM = -fx_wide_t'(2 ** (DATA_W - 1));

    // Select the upper limit, the lower limit, or the value itself.
    always_comb begin
        if (wide_i > POS_LIM) begin
            res_o.value   = fx_t'(POS_LIM);
            res_o.clamped = 1'b1;
        end else if (wide_i < NEG_LIM) begin
            res_o.value   = fx_t'(NEG_LIM);
            res_o.clamped = 1'b1;
        end else begin
            res_o.value   = wide_i[DATA_W-1:0];
            res_o.clamped = 1'b0;
        end
    end
endmodule

// File: rtl/fxm_out_stage.sv
// fxm_out_stage: optional single output register with valid/ready.
// OUT_REG=1 gives one full-throughput register stage. OUT_REG=0 is a
// combinational pass-through. Reset is synchronous and active low.
module fxm_out_stage
    import fxm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    output logic    in_ready,
    input  fx_res_t in_data,
    output logic    out_valid,
    input  logic    out_ready,
    output fx_res_t out_data
);
    generate
        if (OUT_REG) begin : g_reg
            logic    vld_q;
            fx_res_t dat_q;

            // Accept when the register is empty or being drained.
            always_comb begin
                in_ready = !vld_q || out_ready;
            end

            // Load a new result or clear the valid bit on each accepted slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    dat_q <= '0;
                end else if (in_ready) begin
                    vld_q <= in_valid;
                    if (in_valid) begin
                        dat_q <= in_data;
                    end
                end
            end

            // Drive the outputs from the register.
            always_comb begin
                out_valid = vld_q;
                out_data  = dat_q;
            end

            AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data))); // R6
            AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
            AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_ready && !in_valid) |=> !out_valid); // R8
        end else begin : g_pass
            // Forward the handshake and the data without storage.
            always_comb begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_data  = in_data;
            end
        end
    endgenerate
endmodule

// File: rtl/fxm_mul_round_sat.sv
// fxm_mul_round_sat: signed fixed-point multiply with round-half-up and
// saturation. Operands and result share FRAC_BITS fraction bits.
// Assumes 1 <= FRAC_BITS <= 15. Reset is synchronous and active low.
module fxm_mul_round_sat
    import fxm_pkg::*;
#(
    parameter int FRAC_BITS = 8,
    parameter bit OUT_REG   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] res_o,
    output logic        ovf_o
);
    generate
        if (FRAC_BITS < 1 || FRAC_BITS > 15) begin : g_bad_frac
            $error("FRAC_BITS must lie in 1..15");
        end
    endgenerate

    fx_wide_t prod;
    fx_wide_t scaled;
    fx_res_t  sat_res;
    fx_res_t  stage_res;

    fxm_product u_prod (
        .a_i    (fx_t'(op_a)),
        .b_i    (fx_t'(op_b)),
        .prod_o (prod)
    );

    fxm_rescale #(.FRAC_BITS(FRAC_BITS)) u_rescale (
        .prod_i   (prod),
        .scaled_o (scaled)
    );

    fxm_saturate u_sat (
        .wide_i (scaled),
        .res_o  (sat_res)
    );

    fxm_out_stage #(.OUT_REG(OUT_REG)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (sat_res),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (stage_res)
    );

    // Present the result and gate the flag with the valid bit.
    always_comb begin
        res_o = stage_res.value;
        ovf_o = out_valid && stage_res.clamped;
    end

    AST_CLAMP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        sat_res.clamped |-> (sat_res.value == 16'h7FFF || sat_res.value == 16'h8000)); // R3
    AST_CLAMP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        sat_res.clamped |-> (sat_res.value[15] == scaled[PROD_W-1])); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sat_res.clamped |-> (sat_res.value == scaled[DATA_W-1:0])); // R5
    AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> out_valid); // R5
endmodule

// File: tb/fxm_mul_round_sat_tb.sv
// Bench: behavioural model of the handshake and the arithmetic, compared
// with the design on every falling clock edge.
module fxm_mul_round_sat_tb_top;
    localparam int FRAC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] res_o;
    logic        ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state.
    bit          m_valid = 1'b0;
    logic [15:0] m_res   = '0;
    bit          m_ovf   = 1'b0;
    bit          m_half  = 1'b0;
    bit          stalled = 1'b0;

    always #5 clk = ~clk;

    fxm_mul_round_sat #(.FRAC_BITS(FRAC), .OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
        .res_o(res_o), .ovf_o(ovf_o)
    );

    function automatic longint ref_scaled(logic [15:0] a, logic [15:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        p = p + (longint'(1) << (FRAC - 1));
        return p >>> FRAC;
    endfunction

    function automatic bit is_half(logic [15:0] a, logic [15:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        return (p & ((longint'(1) << FRAC) - 1)) == (longint'(1) << (FRAC - 1));
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model register: same slot rules as the requirements (R6, R8).
    always @(posedge clk) begin
        longint s;
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_ovf   <= 1'b0;
            stalled <= 1'b0;
        end else begin
            stalled <= m_valid && !out_ready;
            if (!m_valid || out_ready) begin
                m_valid <= in_valid;
                if (in_valid) begin
                    s = ref_scaled(op_a, op_b);
                    m_half <= is_half(op_a, op_b);
                    if (s > 32767) begin
                        m_res <= 16'h7FFF; m_ovf <= 1'b1;
                    end else if (s < -32768) begin
                        m_res <= 16'h8000; m_ovf <= 1'b1;
                    end else begin
                        m_res <= s[15:0]; m_ovf <= 1'b0;
                    end
                end
            end
        end
    end

    task automatic compare();
        string tag;
        check(in_ready == (!m_valid || out_ready), "R8 in_ready", in_ready, !m_valid || out_ready);
        check(out_valid == m_valid, stalled ? "R7 out_valid hold" : "R6 out_valid", out_valid, m_valid);
        if (m_valid) begin
            if (stalled)                tag = "R7 held result";
            else if (m_ovf && !m_res[15]) tag = "R3 positive clamp";
            else if (m_ovf)             tag = "R4 negative clamp";
            else if (m_half)            tag = "R2 halfway";
            else                        tag = "R1 result";
            check(res_o == m_res, tag, res_o, m_res);
            check(ovf_o == m_ovf, m_ovf ? tag : "R5 no clamp flag", ovf_o, m_ovf);
        end else begin
            check(ovf_o == 1'b0, "R5 flag without valid", ovf_o, 0);
        end
    endtask

    task automatic step(bit v, logic [15:0] a, logic [15:0] b, bit rdy);
        @(negedge clk);
        compare();
        in_valid  = v;
        op_a      = a;
        op_b      = b;
        out_ready = rdy;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: state after reset
        check(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
        check(ovf_o == 1'b0, "R9 ovf after reset", ovf_o, 0);
        // Directed: halfway cases (R2), extremes (R10, R3, R4), identities (R1).
        step(1, 16'd1, 16'd128, 1);
        step(1, 16'hFFFF, 16'd128, 1);
        step(1, 16'hFFFD, 16'd128, 1);
        step(1, 16'h8000, 16'h8000, 1);
        step(1, 16'h7FFF, 16'h7FFF, 1);
        step(1, 16'h8000, 16'h7FFF, 1);
        step(1, 16'h0100, 16'h1234, 1);
        step(1, 16'h0000, 16'h7FFF, 1);
        step(1, 16'h0800, 16'hF000, 1);
        step(0, 16'h0, 16'h0, 1);
        // R7: hold a result under back-pressure for several cycles.
        step(1, 16'h7FFF, 16'h0400, 0);
        step(0, 16'h0, 16'h0, 0);
        step(1, 16'h0001, 16'h0001, 0);
        step(1, 16'h0001, 16'h0001, 0);
        step(1, 16'h0001, 16'h0001, 1);
        // Random: small operands, large operands, random ready.
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a, b;
            if (i % 2 == 0) begin
                a = 16'($signed(8'($urandom)));
                b = 16'($urandom);
            end else begin
                a = 16'($urandom);
                b = 16'($urandom);
            end
            step(1'($urandom % 4 != 0), a, b, 1'($urandom % 3 != 0));
        end
        step(0, 16'h0, 16'h0, 1);
        step(0, 16'h0, 16'h0, 1);
        @(negedge clk);
        compare();
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule